// File: doc/BRIEF.md
# Indirect Register Access Port

This block is a small bank of 64-bit registers on a configuration bus that opens a window into a larger target register space. Software first loads a 12-bit target address into the address register. Each later read or write of the data register becomes one 8-byte access at that address on a separate target port, and the bus response waits until the target answers. The data register holds nothing of its own.

Beside the address/data pair, the bank holds a sticky status register. Software clears its bits by writing ones to them. An external set vector raises them, and a set wins over a clear of the same bit in the same cycle. Two auxiliary registers, an enable and a timer, take writes and drop them. A write to any index outside the map is flagged as an error in the response.

A controller with three states handles the bus. In ST_IDLE it waits for a request. A data-register access moves it to ST_FWD, and every other access moves it straight to ST_RESP. ST_FWD holds the target request until the target acknowledges and then moves to ST_RESP. ST_RESP presents the acknowledge for one cycle and returns to ST_IDLE.

Top module: `indir_access_port`

## Requirements
- R1: The register index is bus_addr divided by 8, and the low three address bits are ignored. Index 0 is the address register, 1 the data register, 2 status, 3 the auxiliary enable and 4 the auxiliary timer. Every other index is unmapped. All accesses are 64 bits wide.
- R2: A write to the address register stores bits 11:0 of bus_wdata. A read of it returns the stored 12 bits, zero-extended.
- R3: A read of the data register issues exactly one target read (tgt_req with tgt_we=0) at the stored address. The bus read data is tgt_rdata as captured in the cycle of tgt_ack.
- R4: A write of the data register issues exactly one target write (tgt_we=1) at the stored address, carrying bus_wdata as tgt_wdata.
- R5: tgt_req stays high, with tgt_addr, tgt_we and tgt_wdata stable, until tgt_ack is seen. bus_ack stays low while tgt_req is high and rises in the cycle after tgt_ack.
- R6: A write to status clears each status bit whose corresponding bit in bus_wdata is 1 and leaves the others unchanged. A read of status returns the stored bits, zero-extended.
- R7: A 1 on stat_set sets that status bit at the next clock edge. A set wins over a write-one-to-clear of the same bit in the same cycle.
- R8: Writes to the auxiliary enable and timer registers change no state and raise no error. Reads of these registers return zero.
- R9: A write to an unmapped index returns bus_err=1 with its bus_ack and changes no register. A read of an unmapped index returns zero with no error.
- R10: An access to a register other than the data register is acknowledged one cycle after it is accepted. bus_ack is always a single-cycle pulse, and write responses carry zero read data.
- R11: After reset the address and status registers are zero and tgt_req and bus_ack are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Bus request, held until bus_ack |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | BAW (6) | Byte address of the register |
| bus_wdata | input | DW (64) | Write data |
| bus_ack | output | 1 | One-cycle response strobe |
| bus_rdata | output | DW (64) | Read data, valid with bus_ack |
| bus_err | output | 1 | Unmapped write, valid with bus_ack |
| tgt_req | output | 1 | Target access request |
| tgt_we | output | 1 | Target access direction |
| tgt_addr | output | TAW (12) | Target register address |
| tgt_wdata | output | DW (64) | Target write data |
| tgt_ack | input | 1 | Target acknowledge |
| tgt_rdata | input | DW (64) | Target read data, valid with tgt_ack |
| stat_set | input | SW (8) | Per-bit status set pulses |

## Verification
The hardest case to reach from the ports is a status write that clears a bit while stat_set raises the same bit in the same edge. The bus task drives stat_set in the cycle that the request is accepted and drops it one cycle later, so random and directed status writes meet set pulses at exactly that edge. Target latency is randomised per access, which holds ST_FWD for a varying number of cycles. Unmapped and auxiliary writes are always followed by reads of the address and status registers to show that nothing moved.

// File: rtl/indir_pkg.sv
package indir_pkg;

    // Register indices (byte address / 8); software depends on these positions
    localparam int unsigned IDX_ADDR   = 0;
    localparam int unsigned IDX_DATA   = 1;
    localparam int unsigned IDX_STAT   = 2;
    localparam int unsigned IDX_AUXEN  = 3;
    localparam int unsigned IDX_AUXTMR = 4;

    typedef enum logic [2:0] {
        SEL_ADDR,
        SEL_DATA,
        SEL_STAT,
        SEL_AUXEN,
        SEL_AUXTMR,
        SEL_NONE
    } sel_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FWD,
        ST_RESP
    } state_e;

endpackage

// File: rtl/indir_decode.sv
module indir_decode
    import indir_pkg::*;
#(
    parameter int unsigned BAW = 6
) (
    input  logic [BAW-1:0] bus_addr,
    output sel_e           sel
);
    localparam int unsigned IW = BAW - 3;

    logic [IW-1:0] idx;

    // Low three bits select a byte inside the 64-bit word and are dropped
    assign idx = bus_addr[BAW-1:3];

    always_comb begin
        if      (int'(idx) == IDX_ADDR)   sel = SEL_ADDR;
        else if (int'(idx) == IDX_DATA)   sel = SEL_DATA;
        else if (int'(idx) == IDX_STAT)   sel = SEL_STAT;
        else if (int'(idx) == IDX_AUXEN)  sel = SEL_AUXEN;
        else if (int'(idx) == IDX_AUXTMR) sel = SEL_AUXTMR;
        else                              sel = SEL_NONE;
    end

endmodule

// File: rtl/indir_status.sv
module indir_status #(
    parameter int unsigned SW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] clr_i,
    input  logic [SW-1:0] set_i,
    output logic [SW-1:0] q_o
);
    // Clear first, then set: a coincident set survives
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_o <= '0;
        else        q_o <= (q_o & ~clr_i) | set_i;
    end

endmodule

// File: rtl/indir_ctrl.sv
module indir_ctrl
    import indir_pkg::*;
#(
    parameter int unsigned DW  = 64,
    parameter int unsigned TAW = 12,
    parameter int unsigned SW  = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_req,
    input  logic           bus_we,
    input  sel_e           sel,
    input  logic [DW-1:0]  bus_wdata,
    input  logic [SW-1:0]  status_q,
    output logic           bus_ack,
    output logic [DW-1:0]  bus_rdata,
    output logic           bus_err,
    output logic           tgt_req,
    output logic           tgt_we,
    output logic [TAW-1:0] tgt_addr,
    output logic [DW-1:0]  tgt_wdata,
    input  logic           tgt_ack,
    input  logic [DW-1:0]  tgt_rdata,
    output logic [SW-1:0]  stat_clr
);
    state_e         state_q, state_d;
    logic [TAW-1:0] addr_q;
    logic           we_q;
    logic [DW-1:0]  wdata_q;
    logic [DW-1:0]  rdata_q;
    logic           err_q;
    logic           accept;
    logic [DW-1:0]  local_rdata;

    assign accept = (state_q == ST_IDLE) && bus_req;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (bus_req) state_d = (sel == SEL_DATA) ? ST_FWD : ST_RESP;
            ST_FWD:  if (tgt_ack) state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Read value of the locally held registers
    always_comb begin
        local_rdata = '0;
        if (!bus_we) begin
            unique case (sel)
                SEL_ADDR: local_rdata = DW'(addr_q);
                SEL_STAT: local_rdata = DW'(status_q);
                default:  local_rdata = '0;
            endcase
        end
    end

    // Address register and response capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            we_q    <= 1'b0;
            wdata_q <= '0;
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else if (accept) begin
            we_q    <= bus_we;
            wdata_q <= bus_wdata;
            rdata_q <= local_rdata;
            err_q   <= bus_we && (sel == SEL_NONE);
            if (bus_we && (sel == SEL_ADDR)) addr_q <= bus_wdata[TAW-1:0];
        end else if ((state_q == ST_FWD) && tgt_ack) begin
            rdata_q <= we_q ? '0 : tgt_rdata;
            err_q   <= 1'b0;
        end
    end

    // Outputs
    always_comb begin
        bus_ack   = (state_q == ST_RESP);
        bus_rdata = bus_ack ? rdata_q : '0;
        bus_err   = bus_ack && err_q;
        tgt_req   = (state_q == ST_FWD);
        tgt_we    = we_q;
        tgt_addr  = addr_q;
        tgt_wdata = wdata_q;
        stat_clr  = (accept && bus_we && (sel == SEL_STAT)) ? bus_wdata[SW-1:0] : '0;
    end

endmodule

// File: rtl/indir_access_port.sv
module indir_access_port
    import indir_pkg::*;
#(
    parameter int unsigned DW  = 64,
    parameter int unsigned BAW = 6,
    parameter int unsigned TAW = 12,
    parameter int unsigned SW  = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_req,
    input  logic           bus_we,
    input  logic [BAW-1:0] bus_addr,
    input  logic [DW-1:0]  bus_wdata,
    output logic           bus_ack,
    output logic [DW-1:0]  bus_rdata,
    output logic           bus_err,
    output logic           tgt_req,
    output logic           tgt_we,
    output logic [TAW-1:0] tgt_addr,
    output logic [DW-1:0]  tgt_wdata,
    input  logic           tgt_ack,
    input  logic [DW-1:0]  tgt_rdata,
    input  logic [SW-1:0]  stat_set
);
    sel_e          sel;
    logic [SW-1:0] status_q;
    logic [SW-1:0] stat_clr;

    indir_decode #(.BAW(BAW)) u_decode (
        .bus_addr (bus_addr),
        .sel      (sel)
    );

    indir_status #(.SW(SW)) u_status (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (stat_clr),
        .set_i (stat_set),
        .q_o   (status_q)
    );

    indir_ctrl #(.DW(DW), .TAW(TAW), .SW(SW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .sel       (sel),
        .bus_wdata (bus_wdata),
        .status_q  (status_q),
        .bus_ack   (bus_ack),
        .bus_rdata (bus_rdata),
        .bus_err   (bus_err),
        .tgt_req   (tgt_req),
        .tgt_we    (tgt_we),
        .tgt_addr  (tgt_addr),
        .tgt_wdata (tgt_wdata),
        .tgt_ack   (tgt_ack),
        .tgt_rdata (tgt_rdata),
        .stat_clr  (stat_clr)
    );

endmodule

// File: rtl/indir_access_port_chk.sv
module indir_access_port_chk #(
    parameter int unsigned DW  = 64,
    parameter int unsigned TAW = 12,
    parameter int unsigned SW  = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           bus_ack,
    input logic           bus_err,
    input logic           tgt_req,
    input logic           tgt_ack,
    input logic           tgt_we,
    input logic [TAW-1:0] tgt_addr,
    input logic [DW-1:0]  tgt_wdata,
    input logic [SW-1:0]  stat_set,
    input logic [SW-1:0]  status_q
);
    a_r5_tgt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_req && !tgt_ack) |=> (tgt_req && $stable(tgt_addr) && $stable(tgt_we) && $stable(tgt_wdata)));

    a_r5_no_early_ack: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_req |-> !bus_ack);

    a_r5_ack_after_tgt: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_req && tgt_ack) |=> bus_ack);

    a_r10_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> !bus_ack);

    a_r9_err_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> bus_ack);

    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|stat_set) |=> ((status_q & $past(stat_set)) == $past(stat_set)));

endmodule

bind indir_access_port indir_access_port_chk #(.DW(DW), .TAW(TAW), .SW(SW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_ack   (bus_ack),
    .bus_err   (bus_err),
    .tgt_req   (tgt_req),
    .tgt_ack   (tgt_ack),
    .tgt_we    (tgt_we),
    .tgt_addr  (tgt_addr),
    .tgt_wdata (tgt_wdata),
    .stat_set  (stat_set),
    .status_q  (status_q)
);

// File: tb/tb_indir_access_port.sv
module tb_indir_access_port;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [63:0] bus_wdata = '0;
    logic        bus_ack, bus_err;
    logic [63:0] bus_rdata;
    logic        tgt_req, tgt_we;
    logic [11:0] tgt_addr;
    logic [63:0] tgt_wdata;
    logic        tgt_ack = 1'b0;
    logic [63:0] tgt_rdata = '0;
    logic [7:0]  stat_set = '0;

    int checks = 0, errors = 0;
    int tlat = 0, wcnt = 0, tcnt = 0;
    logic [11:0] rec_addr;
    logic        rec_we;
    logic [63:0] rec_wdata;
    logic [11:0] m_addr = '0;
    logic [7:0]  m_stat = '0;
    bit          done = 0;

    indir_access_port dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [63:0] tmodel(input logic [11:0] a);
        return 64'h9E3779B97F4A7C15 ^ {a, a, a, a, a, 4'h5};
    endfunction

    // Target responder
    always @(negedge clk) begin
        if (tgt_ack) tgt_ack = 1'b0;
        else if (tgt_req) begin
            if (wcnt >= tlat) begin
                tgt_ack = 1'b1;
                tgt_rdata = tmodel(tgt_addr);
                rec_addr = tgt_addr; rec_we = tgt_we; rec_wdata = tgt_wdata;
                tcnt++; wcnt = 0;
            end else wcnt++;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One bus access; setv drives stat_set in the acceptance cycle only
    task automatic do_op(input logic we, input logic [5:0] ba, input logic [63:0] wd, input logic [7:0] setv);
        int idx = int'(ba[5:3]);
        int n;
        int t0 = tcnt;
        logic [63:0] exp_rd;
        logic exp_err = we && (idx > 4);
        string tag;
        exp_rd = '0;
        if (!we) begin
            if (idx == 0) exp_rd = {52'd0, m_addr};
            else if (idx == 1) exp_rd = tmodel(m_addr);
            else if (idx == 2) exp_rd = {56'd0, m_stat};
        end
        case (idx)
            0: tag = "R2"; 1: tag = we ? "R4" : "R3"; 2: tag = "R6";
            3, 4: tag = "R8"; default: tag = "R9";
        endcase
        bus_req = 1; bus_we = we; bus_addr = ba; bus_wdata = wd; stat_set = setv;
        @(negedge clk); stat_set = '0; n = 1;
        while (!bus_ack && n < 60) begin @(negedge clk); n++; end
        chk(bus_ack === 1'b1, "R10 ack", {63'd0, bus_ack}, 64'd1);
        chk(bus_rdata === exp_rd, tag, bus_rdata, exp_rd);
        chk(bus_err === exp_err, exp_err ? "R9 err" : "R8/R9 no err", {63'd0, bus_err}, {63'd0, exp_err});
        if (idx == 1) begin
            chk(tcnt == t0 + 1, "R1 one target access", 64'(tcnt - t0), 64'd1);
            chk(rec_addr === m_addr && rec_we === we, "R3/R4 target addr/dir", {51'd0, rec_we, rec_addr}, {51'd0, we, m_addr});
            if (we) chk(rec_wdata === wd, "R4 wdata", rec_wdata, wd);
            chk(n == tlat + 2, "R5 latency", 64'(n), 64'(tlat + 2));
        end else begin
            chk(tcnt == t0, "R1 no target access", 64'(tcnt - t0), 64'd0);
            chk(n == 1, "R10 local latency", 64'(n), 64'd1);
        end
        bus_req = 0;
        @(negedge clk);
        chk(bus_ack === 1'b0, "R10 pulse", {63'd0, bus_ack}, 64'd0);
        if (we && idx == 0) m_addr = wd[11:0];
        if (we && idx == 2) m_stat = (m_stat & ~wd[7:0]) | setv;
        else m_stat = m_stat | setv;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'hC0FFEE));
        repeat (3) @(negedge clk);
        chk(bus_ack === 0 && tgt_req === 0, "R11 reset outputs", {62'd0, bus_ack, tgt_req}, 64'd0);
        rst_n = 1;
        @(negedge clk);
        do_op(0, 6'h00, 0, 0);                      // R11 addr zero
        do_op(0, 6'h10, 0, 0);                      // R11 status zero
        do_op(1, 6'h05, 64'hFFFF_FFFF_FFFF_FABC, 0); // R1 low bits ignored, R2 keep 12 bits
        do_op(0, 6'h00, 0, 0);
        tlat = 0; do_op(0, 6'h08, 0, 0);            // R3 immediate ack
        tlat = 3; do_op(1, 6'h0F, 64'h1234_5678_9ABC_DEF0, 0); // R4, R5 wait
        do_op(0, 6'h10, 0, 8'hA5);                  // R7 set via input
        do_op(0, 6'h10, 0, 0);
        do_op(1, 6'h10, 64'h81, 8'h01);             // R7 set wins over clear of bit0; R6 clears bit7
        do_op(0, 6'h10, 0, 0);
        do_op(1, 6'h18, '1, 0);                     // R8 aux enable
        do_op(1, 6'h20, '1, 0);                     // R8 aux timer
        do_op(0, 6'h18, 0, 0);
        do_op(1, 6'h28, '1, 0);                     // R9 unmapped write
        do_op(1, 6'h38, '1, 0);
        do_op(0, 6'h30, 0, 0);                      // R9 unmapped read
        do_op(0, 6'h00, 0, 0);
        do_op(0, 6'h10, 0, 0);
        for (int i = 0; i < 400; i++) begin
            logic [63:0] wd = {$urandom, $urandom};
            tlat = int'($urandom_range(0, 4));
            do_op(1'($urandom), 6'($urandom), wd, ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'h00);
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule